// File: doc/BRIEF.md
# Banked Level Interrupt Controller

This block gathers a wide set of level-sensitive interrupt lines into a small number of 32-bit banks. Each line is captured in a sticky pending flag. The flag then passes two separate gates before it can reach the processor: an enable bit and a mask bit. All gated requests are ORed together into a single registered interrupt line.

Software works the controller through a plain 32-bit register port. Reads are combinational and carry no wait states. Writes take effect on the clock edge.

- Pending flags are cleared by writing ones.
- Each bank has a read-only status word that lists requests which are enabled but held back by their mask.
- A protection switch restricts writes to privileged accesses.
- A small control field stores the trigger selection for the external non-maskable line, which is source 0.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset every enable bit is 0, every mask bit is 1, every pending bit is 0, the protection bit and the trigger field are 0, and `irq_o` is low.
- R2: A pending bit becomes 1 on any clock edge at which its source input is high. It stays 1 after the source drops, until software clears it.
- R3: A write to byte offset 0x10+4k clears each pending bit of bank k whose data bit is 1. Data bits of 0 leave their pending bits unchanged. If the source is high on the same edge, the source wins and the bit stays 1.
- R4: The enable word of bank k lives at 0x40+4k and the mask word at 0x50+4k. Both are read/write, and each reads back the last accepted value.
- R5: `irq_o` is 1 exactly one clock after some source is pending, enabled and unmasked (mask bit 0). It returns to 0 one clock after no such source remains.
- R6: The word at 0x20+4k is read-only and returns pending AND enable AND mask for bank k. Writes to it change nothing.
- R7: Bit 0 at offset 0x08 is the protection switch. Bits 1:0 at offset 0x0c hold the trigger selection for the external line. Other bits of these two words read 0.
- R8: While protection is on, writes that arrive with `bus_priv_i` low are dropped, and writes with it high are accepted. Reads always return data.
- R9: Offsets that name no register read as 0, and writes to them have no effect on any register.
- R10: Source n maps to bank n/32, bit n%32. Source 0 (the external line) keeps its pending bit after it becomes enabled, and the bit stays set until it is cleared explicitly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_BANKS*BANK_W | Level interrupt inputs, one per source |
| bus_valid_i | input | 1 | Register access strobe |
| bus_write_i | input | 1 | 1 for write, 0 for read |
| bus_priv_i | input | 1 | Access is privileged |
| bus_addr_i | input | ADDR_W | Byte offset of the access |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for the current offset (combinational) |
| irq_o | output | 1 | Registered interrupt request to the processor |

## Verification
The assertions assume three things about the inputs:
- Source inputs and bus fields are stable around the clock edge.
- A pending bit can fall only on a cycle with a bus write.
- The protection check relies on `bus_priv_i` being meaningful whenever `bus_valid_i` and `bus_write_i` are high.

The stimulus drives every input half a cycle away from the sampling edge. Random offsets are drawn from the defined register set plus a few holes. Random source patterns are kept sparse by ANDing several random words, so that clearing writes and set events both have a visible effect.

// File: rtl/bic_pkg.sv
`timescale 1ns/1ps
package bic_pkg;
   // Byte offsets of the register words; banked words step by BANK_STRIDE.
   localparam int unsigned OFF_PROT    = 32'h08;
   localparam int unsigned OFF_TRIG    = 32'h0C;
   localparam int unsigned OFF_PEND    = 32'h10;
   localparam int unsigned OFF_HELD    = 32'h20;
   localparam int unsigned OFF_ENAB    = 32'h40;
   localparam int unsigned OFF_MASK    = 32'h50;
   localparam int unsigned BANK_STRIDE = 4;
   localparam int unsigned MAX_BANKS   = 4;
   localparam int unsigned TRIG_W      = 2;

   typedef struct packed {
      logic       prot;
      logic [TRIG_W-1:0] trig;
   } bic_ctrl_t;
endpackage

// File: rtl/bic_bank.sv
`timescale 1ns/1ps
module bic_bank #(
   parameter int unsigned BANK_W = 32,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BANK_W-1:0] src_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              clr_pend_i,
   input  logic              wr_enab_i,
   input  logic              wr_mask_i,
   output logic [BANK_W-1:0] pend_o,
   output logic [BANK_W-1:0] enab_o,
   output logic [BANK_W-1:0] mask_o,
   output logic [BANK_W-1:0] held_o,
   output logic              req_o
);
   logic [BANK_W-1:0] wbits;
   logic [BANK_W-1:0] clr_bits;
   logic [BANK_W-1:0] pend_q, enab_q, mask_q;

   generate
      if (DATA_W > BANK_W) begin : g_trim
         logic [DATA_W-BANK_W-1:0] spare;
         assign wbits = wdata_i[BANK_W-1:0];
         assign spare = wdata_i[DATA_W-1:BANK_W];
      end else begin : g_full
         assign wbits = wdata_i;
      end
   endgenerate

   assign clr_bits = clr_pend_i ? wbits : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         enab_q <= '0;
         mask_q <= '1;
      end else begin
         // level input dominates a same-edge clear
         pend_q <= (pend_q & ~clr_bits) | src_i;
         if (wr_enab_i) enab_q <= wbits;
         if (wr_mask_i) mask_q <= wbits;
      end
   end

   assign pend_o = pend_q;
   assign enab_o = enab_q;
   assign mask_o = mask_q;
   assign held_o = pend_q & enab_q & mask_q;
   assign req_o  = |(pend_q & enab_q & ~mask_q);
endmodule

// File: rtl/bic_regbus.sv
`timescale 1ns/1ps
module bic_regbus
   import bic_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 3,
   parameter int unsigned BANK_W    = 32,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 10,
   localparam int unsigned NUM_SRC  = NUM_BANKS * BANK_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               valid_i,
   input  logic               write_i,
   input  logic               priv_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic [DATA_W-1:0]  wdata_i,
   input  logic [NUM_SRC-1:0] pend_i,
   input  logic [NUM_SRC-1:0] enab_i,
   input  logic [NUM_SRC-1:0] mask_i,
   input  logic [NUM_SRC-1:0] held_i,
   output logic [NUM_BANKS-1:0] clr_pend_o,
   output logic [NUM_BANKS-1:0] wr_enab_o,
   output logic [NUM_BANKS-1:0] wr_mask_o,
   output logic [DATA_W-1:0]  rdata_o,
   output logic               prot_o
);
   bic_ctrl_t ctrl_q;
   logic      wr_ok;

   assign wr_ok  = valid_i && write_i && (!ctrl_q.prot || priv_i);
   assign prot_o = ctrl_q.prot;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_ok) begin
         if (addr_i == ADDR_W'(OFF_PROT)) ctrl_q.prot <= wdata_i[0];
         if (addr_i == ADDR_W'(OFF_TRIG)) ctrl_q.trig <= wdata_i[TRIG_W-1:0];
      end
   end

   always_comb begin
      for (int k = 0; k < NUM_BANKS; k++) begin
         clr_pend_o[k] = wr_ok && (addr_i == ADDR_W'(OFF_PEND + BANK_STRIDE*k));
         wr_enab_o[k]  = wr_ok && (addr_i == ADDR_W'(OFF_ENAB + BANK_STRIDE*k));
         wr_mask_o[k]  = wr_ok && (addr_i == ADDR_W'(OFF_MASK + BANK_STRIDE*k));
      end
   end

   always_comb begin
      rdata_o = '0;
      if (addr_i == ADDR_W'(OFF_PROT)) rdata_o[0] = ctrl_q.prot;
      if (addr_i == ADDR_W'(OFF_TRIG)) rdata_o[TRIG_W-1:0] = ctrl_q.trig;
      for (int k = 0; k < NUM_BANKS; k++) begin
         if (addr_i == ADDR_W'(OFF_PEND + BANK_STRIDE*k))
            rdata_o[BANK_W-1:0] = pend_i[k*BANK_W +: BANK_W];
         if (addr_i == ADDR_W'(OFF_HELD + BANK_STRIDE*k))
            rdata_o[BANK_W-1:0] = held_i[k*BANK_W +: BANK_W];
         if (addr_i == ADDR_W'(OFF_ENAB + BANK_STRIDE*k))
            rdata_o[BANK_W-1:0] = enab_i[k*BANK_W +: BANK_W];
         if (addr_i == ADDR_W'(OFF_MASK + BANK_STRIDE*k))
            rdata_o[BANK_W-1:0] = mask_i[k*BANK_W +: BANK_W];
      end
   end
endmodule

// File: rtl/banked_irq_ctrl.sv
`timescale 1ns/1ps
module banked_irq_ctrl
   import bic_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 3,
   parameter int unsigned BANK_W    = 32,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 10,
   localparam int unsigned NUM_SRC  = NUM_BANKS * BANK_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic               bus_valid_i,
   input  logic               bus_write_i,
   input  logic               bus_priv_i,
   input  logic [ADDR_W-1:0]  bus_addr_i,
   input  logic [DATA_W-1:0]  bus_wdata_i,
   output logic [DATA_W-1:0]  bus_rdata_o,
   output logic               irq_o
);
   generate
      if (NUM_BANKS < 1 || NUM_BANKS > MAX_BANKS) begin : g_bad_banks
         $error("NUM_BANKS must lie in 1..%0d", MAX_BANKS);
      end
      if (BANK_W < TRIG_W || BANK_W > DATA_W) begin : g_bad_width
         $error("BANK_W must lie in TRIG_W..DATA_W");
      end
      if (ADDR_W < 7) begin : g_bad_addr
         $error("ADDR_W too small for the register window");
      end
   endgenerate

   logic [NUM_SRC-1:0]   pend_all, enab_all, mask_all, held_all;
   logic [NUM_BANKS-1:0] clr_pend, wr_enab, wr_mask, bank_req;
   logic                 prot;
   logic                 irq_q;

   bic_regbus #(
      .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W),
      .DATA_W(DATA_W), .ADDR_W(ADDR_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .valid_i(bus_valid_i), .write_i(bus_write_i), .priv_i(bus_priv_i),
      .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
      .pend_i(pend_all), .enab_i(enab_all), .mask_i(mask_all), .held_i(held_all),
      .clr_pend_o(clr_pend), .wr_enab_o(wr_enab), .wr_mask_o(wr_mask),
      .rdata_o(bus_rdata_o), .prot_o(prot)
   );

   for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
      bic_bank #(.BANK_W(BANK_W), .DATA_W(DATA_W)) u_bank (
         .clk(clk), .rst_n(rst_n),
         .src_i(src_i[k*BANK_W +: BANK_W]),
         .wdata_i(bus_wdata_i),
         .clr_pend_i(clr_pend[k]), .wr_enab_i(wr_enab[k]), .wr_mask_i(wr_mask[k]),
         .pend_o(pend_all[k*BANK_W +: BANK_W]),
         .enab_o(enab_all[k*BANK_W +: BANK_W]),
         .mask_o(mask_all[k*BANK_W +: BANK_W]),
         .held_o(held_all[k*BANK_W +: BANK_W]),
         .req_o(bank_req[k])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |bank_req;
   end

   assign irq_o = irq_q;
endmodule

// File: rtl/bic_checker.sv
`timescale 1ns/1ps
module bic_checker #(
   parameter int unsigned NUM_SRC = 96
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] src_i,
   input logic               bus_valid_i,
   input logic               bus_write_i,
   input logic               bus_priv_i,
   input logic               prot,
   input logic [NUM_SRC-1:0] pend_all,
   input logic [NUM_SRC-1:0] enab_all,
   input logic [NUM_SRC-1:0] mask_all,
   input logic               irq_o
);
   assert_pend_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (|src_i) |=> ((pend_all & $past(src_i)) == $past(src_i)));

   assert_pend_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_valid_i && bus_write_i) |=> ((pend_all & $past(pend_all)) == $past(pend_all)));

   assert_irq_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_o == $past(|(pend_all & enab_all & ~mask_all))));

   assert_prot_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (prot && bus_valid_i && bus_write_i && !bus_priv_i) |=>
         ($stable(enab_all) && $stable(mask_all)));

   assert_nmi_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_all[0] && !(bus_valid_i && bus_write_i)) |=> pend_all[0]);
endmodule

bind banked_irq_ctrl bic_checker #(.NUM_SRC(NUM_SRC)) u_bic_checker (
   .clk(clk), .rst_n(rst_n), .src_i(src_i),
   .bus_valid_i(bus_valid_i), .bus_write_i(bus_write_i), .bus_priv_i(bus_priv_i),
   .prot(prot), .pend_all(pend_all), .enab_all(enab_all), .mask_all(mask_all),
   .irq_o(irq_o)
);

// File: tb/banked_irq_ctrl_test.sv
`timescale 1ns/1ps
module banked_irq_ctrl_test;
   localparam int NB = 3;
   localparam int AW = 10;

   logic          clk = 0;
   logic          rst_n = 0;
   logic [95:0]   src = '0;
   logic          valid = 0, wr = 0, priv = 0;
   logic [AW-1:0] addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic          irq;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   logic [31:0] m_pend [NB];
   logic [31:0] m_enab [NB];
   logic [31:0] m_mask [NB];
   logic        m_prot;
   logic [1:0]  m_trig;

   banked_irq_ctrl #(.NUM_BANKS(NB), .BANK_W(32), .DATA_W(32), .ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .src_i(src),
      .bus_valid_i(valid), .bus_write_i(wr), .bus_priv_i(priv),
      .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
   );

   always #10 clk = ~clk;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_read(int a);
      logic [31:0] r = '0;
      if (a == 'h08) r = {31'b0, m_prot};
      if (a == 'h0C) r = {30'b0, m_trig};
      for (int k = 0; k < NB; k++) begin
         if (a == 'h10 + 4*k) r = m_pend[k];
         if (a == 'h20 + 4*k) r = m_pend[k] & m_enab[k] & m_mask[k];
         if (a == 'h40 + 4*k) r = m_enab[k];
         if (a == 'h50 + 4*k) r = m_mask[k];
      end
      return r;
   endfunction

   function automatic logic exp_irq();
      logic r = 0;
      for (int k = 0; k < NB; k++) r |= |(m_pend[k] & m_enab[k] & ~m_mask[k]);
      return r;
   endfunction

   // one clock with optional write and source pattern; model follows the edge
   task automatic cyc(bit do_wr, int a, logic [31:0] d, bit p, logic [95:0] s);
      bit ok;
      valid = do_wr; wr = do_wr; priv = p; addr = AW'(a); wdata = d; src = s;
      @(posedge clk);
      ok = do_wr && (!m_prot || p);
      for (int k = 0; k < NB; k++) begin
         logic [31:0] clr = (ok && a == 'h10 + 4*k) ? d : 32'h0;
         m_pend[k] = (m_pend[k] & ~clr) | s[k*32 +: 32];
         if (ok && a == 'h40 + 4*k) m_enab[k] = d;
         if (ok && a == 'h50 + 4*k) m_mask[k] = d;
      end
      if (ok && a == 'h08) m_prot = d[0];
      if (ok && a == 'h0C) m_trig = d[1:0];
      @(negedge clk);
      valid = 0; wr = 0; src = '0;
   endtask

   task automatic rd_chk(string req, int a);
      valid = 1; wr = 0; addr = AW'(a);
      #1;
      chk(req, rdata, exp_read(a));
      valid = 0;
   endtask

   task automatic check_all(string req);
      cyc(0, 0, 0, 0, '0);
      chk({req, " irq (R5)"}, {31'b0, irq}, {31'b0, exp_irq()});
      rd_chk({req, " prot (R7)"}, 'h08);
      rd_chk({req, " trig (R7)"}, 'h0C);
      for (int k = 0; k < NB; k++) begin
         rd_chk({req, " pend (R2)"}, 'h10 + 4*k);
         rd_chk({req, " held (R6)"}, 'h20 + 4*k);
         rd_chk({req, " enab (R4)"}, 'h40 + 4*k);
         rd_chk({req, " mask (R4)"}, 'h50 + 4*k);
      end
      rd_chk({req, " hole (R9)"}, 'h1C);
      rd_chk({req, " hole (R9)"}, 'h60);
   endtask

   function automatic logic [95:0] one_src(int n);
      logic [95:0] v = '0;
      v[n] = 1'b1;
      return v;
   endfunction

   initial begin
      #(20 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int pool [12] = '{'h08, 'h0C, 'h10, 'h14, 'h18, 'h20, 'h40, 'h44, 'h48, 'h50, 'h54, 'h30};
      void'($urandom(32'h5EED_1234));
      for (int k = 0; k < NB; k++) begin
         m_pend[k] = '0; m_enab[k] = '0; m_mask[k] = '1;
      end
      m_prot = 0; m_trig = 0;
      repeat (3) @(negedge clk);
      // R1: reset state, sampled before release
      chk("R1 irq", {31'b0, irq}, 32'h0);
      rd_chk("R1 enab0", 'h40);
      rd_chk("R1 mask2", 'h58);
      rd_chk("R1 pend1", 'h14);
      rd_chk("R1 prot", 'h08);
      rst_n = 1;
      @(negedge clk);
      check_all("R1");

      // R10 + R2: external line pulse stays latched through enable/unmask
      cyc(0, 0, 0, 0, one_src(0));
      rd_chk("R10 pend0 latched", 'h10);
      cyc(1, 'h40, 32'h1, 1, '0);
      cyc(1, 'h50, 32'hFFFF_FFFE, 1, '0);
      check_all("R10 nmi enabled");
      chk("R10 nmi irq", {31'b0, irq}, 32'h1);
      cyc(1, 'h10, 32'h1, 1, '0);
      check_all("R3 nmi cleared");
      chk("R3 irq dropped", {31'b0, irq}, 32'h0);

      // R10: source 40 maps to bank 1 bit 8
      cyc(0, 0, 0, 0, one_src(40));
      rd_chk("R10 src40 bank1", 'h14);
      chk("R10 src40 bit8", exp_read('h14), 32'h100);

      // R3: same-edge clear loses to high source; zeros leave bits alone
      cyc(0, 0, 0, 0, one_src(69) | one_src(70));
      cyc(1, 'h18, 32'h20, 1, one_src(69));
      rd_chk("R3 source wins", 'h18);
      cyc(1, 'h18, 32'h0, 1, '0);
      rd_chk("R3 zero write", 'h18);
      cyc(1, 'h18, 32'h60, 1, '0);
      rd_chk("R3 clear both", 'h18);

      // R6: held word and write ignored
      cyc(1, 'h44, 32'h100, 1, '0);
      rd_chk("R6 held", 'h24);
      cyc(1, 'h24, 32'h0, 1, '0);
      check_all("R6 held write");

      // R7 + R8: protection and trigger field
      cyc(1, 'h0C, 32'hFF, 1, '0);
      cyc(1, 'h08, 32'h1, 1, '0);
      cyc(1, 'h40, 32'hDEAD_BEEF, 0, '0);
      cyc(1, 'h0C, 32'h0, 0, '0);
      check_all("R8 unpriv blocked");
      cyc(1, 'h40, 32'h0000_00F0, 1, '0);
      check_all("R8 priv accepted");
      cyc(1, 'h08, 32'h0, 1, '0);

      // R9: writes to holes
      cyc(1, 'h00, 32'hFFFF_FFFF, 1, '0);
      cyc(1, 'h30, 32'hFFFF_FFFF, 1, '0);
      cyc(1, 'h1C, 32'hFFFF_FFFF, 1, '0);
      cyc(1, 'h60, 32'hFFFF_FFFF, 1, '0);
      check_all("R9 hole writes");

      // random phase
      for (int i = 0; i < 400; i++) begin
         logic [95:0] s;
         int a = pool[$urandom_range(11)];
         s = {$urandom & $urandom & $urandom, $urandom & $urandom & $urandom,
              $urandom & $urandom & $urandom};
         if ($urandom_range(3) != 0) s = '0;
         cyc($urandom_range(1), a, $urandom, $urandom_range(1), s);
         if (i % 8 == 7) check_all("R2 random");
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule